// File: doc/BRIEF.md
# Suspend-Exit Wake Signalling Sequencer

This block drives the bus line state when a port leaves suspend. A one-cycle suspend-exit pulse starts a wake sequence. The sequence drives a K state for a fixed number of clock cycles, and how the K ends depends on the port's role.

In the host role, the K is followed by an SE0 window of two low-speed bit times, which is 80 cycles at a 60 MHz clock. If the link ran at high speed before suspend, a one-cycle request to return to high-speed mode is raised in the middle of that window, so the switch happens before the SE0 ends. In the device role, no SE0 is appended. The sequencer briefly drives the idle J of a full- or low-speed link and then releases the bus. A link that was at high speed is released as soon as the K ends.

A host only starts a sequence when an auto-wake enable bit is set. This bit is cleared by reset and is written through a strobe. The role and the speed are captured when a sequence starts, and the sequence runs to completion unaffected by anything else.

Top module: `bus_wake_sequencer`

## Requirements
- R1: After reset the auto-wake enable bit is 0; a cycle with `auto_we`=1 loads `auto_wdata` into it at that clock edge.
- R2: A `wake_evt` pulse seen while idle starts a sequence if `role_host`=0, or if `role_host`=1 and the auto-wake bit is 1. From the next cycle, `line_code` shows K (2'b01) for exactly K_CYCLES cycles. A host `wake_evt` with the auto-wake bit at 0 leaves `line_code` at release (2'b00).
- R3: In the host role, SE0 (2'b10) follows the K directly for exactly SE0_CYCLES cycles, and then `line_code` returns to release (2'b00).
- R4: `hs_mode_req` is a one-cycle pulse. It is raised in the SE0 cycle at zero-based index SE0_CYCLES/2, and only for a host whose captured speed was high speed (`link_speed`=2'b00). It is 0 at all other times.
- R5: In the device role, no SE0 ever follows the K. For a captured speed of full speed (2'b01), low speed (2'b10) or 2'b11, `line_code` shows J (2'b11) for TAIL_CYCLES cycles and then release. For high speed (2'b00), it shows release right after the K.
- R6: `role_host` and `link_speed` are captured in the cycle that starts a sequence. While a sequence runs, `wake_evt` pulses and changes to `role_host` and `link_speed` have no effect on `line_code` or `hs_mode_req`.
- R7: During and right after reset, `line_code` is release (2'b00) and `hs_mode_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_we | input | 1 | Write strobe for the auto-wake enable bit |
| auto_wdata | input | 1 | Value written to the auto-wake enable bit |
| wake_evt | input | 1 | One-cycle suspend-exit event |
| role_host | input | 1 | 1 = host role, 0 = device role |
| link_speed | input | 2 | Pre-suspend speed: 00 high, 01 full, 10 low, 11 treated as full |
| line_code | output | 2 | Line drive: 00 release, 01 K, 10 SE0, 11 J |
| hs_mode_req | output | 1 | One-cycle request to restore high-speed mode |

## Verification
The checker checks on every cycle that:
- a qualified event is followed by K;
- a device K never turns into SE0;
- the high-speed request only appears inside a host SE0 window whose captured speed was high;
- the host SE0 run length equals SE0_CYCLES;
- the captured role and speed stay stable while a sequence is active.

Only the bench scenarios can show the following:
- the exact K length;
- the exact cycle of the mid-window pulse;
- the J tail length for each speed code;
- that a host wake with auto-wake disabled does nothing;
- that noise pulses during a sequence leave it untouched, together with the absence of any trailing restart.

// File: rtl/bus_wake_pkg.sv
package bus_wake_pkg;

    typedef enum logic [1:0] {
        LN_RELEASE = 2'b00,
        LN_K       = 2'b01,
        LN_SE0     = 2'b10,
        LN_J       = 2'b11
    } line_e;

    typedef enum logic [1:0] {
        SPD_HIGH = 2'b00,
        SPD_FULL = 2'b01,
        SPD_LOW  = 2'b10,
        SPD_RSV  = 2'b11
    } speed_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_K    = 2'b01,
        PH_SE0  = 2'b10,
        PH_TAIL = 2'b11
    } phase_e;

    typedef struct packed {
        logic host;
        logic was_hs;
        logic tail_j;
    } wake_ctx_t;

    function automatic wake_ctx_t make_ctx(input logic host, input logic [1:0] spd);
        wake_ctx_t c;
        c.host   = host;
        c.was_hs = (spd == SPD_HIGH);
        c.tail_j = (spd != SPD_HIGH);
        return c;
    endfunction

    function automatic line_e phase_to_line(input phase_e p);
        case (p)
            PH_K:    return LN_K;
            PH_SE0:  return LN_SE0;
            PH_TAIL: return LN_J;
            default: return LN_RELEASE;
        endcase
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/bus_wake_cfg.sv
module bus_wake_cfg (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_val,
    output logic auto_q
);
    always_ff @(posedge clk) begin
        if (rst)        auto_q <= 1'b0;
        else if (wr_en) auto_q <= wr_val;
    end
endmodule

// File: rtl/bus_wake_timer.sv
module bus_wake_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    output logic [CW-1:0] cnt_q
);
    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/bus_wake_ctrl.sv
module bus_wake_ctrl
    import bus_wake_pkg::*;
#(
    parameter int unsigned K_CYCLES   = 1200000,
    parameter int unsigned SE0_CYCLES = 80,
    parameter int unsigned TAIL_CYCLES = 4,
    parameter int unsigned CW         = 21
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  wake_ctx_t     ctx_in,
    input  logic [CW-1:0] cnt,
    output logic          cnt_clr,
    output phase_e        phase_q,
    output wake_ctx_t     ctx_q,
    output logic          hs_pulse
);
    localparam logic [CW-1:0] K_LAST    = CW'(K_CYCLES - 1);
    localparam logic [CW-1:0] SE0_LAST  = CW'(SE0_CYCLES - 1);
    localparam logic [CW-1:0] TAIL_LAST = CW'(TAIL_CYCLES - 1);
    localparam logic [CW-1:0] SE0_MID   = CW'(SE0_CYCLES / 2);

    phase_e phase_d;

    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE: if (start) phase_d = PH_K;
            PH_K: if (cnt == K_LAST) begin
                if (ctx_q.host)        phase_d = PH_SE0;
                else if (ctx_q.tail_j) phase_d = PH_TAIL;
                else                   phase_d = PH_IDLE;
            end
            PH_SE0:  if (cnt == SE0_LAST)  phase_d = PH_IDLE;
            PH_TAIL: if (cnt == TAIL_LAST) phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    assign cnt_clr = (phase_q == PH_IDLE) || (phase_d != phase_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            ctx_q   <= '0;
        end else begin
            phase_q <= phase_d;
            if (phase_q == PH_IDLE && start) ctx_q <= ctx_in;
        end
    end

    assign hs_pulse = (phase_q == PH_SE0) && ctx_q.host && ctx_q.was_hs && (cnt == SE0_MID);
endmodule

// File: rtl/bus_wake_sequencer.sv
module bus_wake_sequencer
    import bus_wake_pkg::*;
#(
    parameter int unsigned K_CYCLES    = 1200000,
    parameter int unsigned SE0_CYCLES  = 80,
    parameter int unsigned TAIL_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       auto_we,
    input  logic       auto_wdata,
    input  logic       wake_evt,
    input  logic       role_host,
    input  logic [1:0] link_speed,
    output logic [1:0] line_code,
    output logic       hs_mode_req
);
    localparam int unsigned MAXC = max3(K_CYCLES, SE0_CYCLES, TAIL_CYCLES);
    localparam int unsigned CW   = $clog2(MAXC + 1);

    logic          auto_q;
    logic          start;
    logic          cnt_clr;
    logic [CW-1:0] cnt;
    phase_e        phase_q;
    wake_ctx_t     ctx_q;
    wake_ctx_t     ctx_in;

    bus_wake_cfg cfg_i (
        .clk(clk), .rst(rst), .wr_en(auto_we), .wr_val(auto_wdata), .auto_q(auto_q)
    );

    assign start  = wake_evt && (role_host ? auto_q : 1'b1);
    assign ctx_in = make_ctx(role_host, link_speed);

    bus_wake_timer #(.CW(CW)) tmr_i (
        .clk(clk), .rst(rst), .clr(cnt_clr), .cnt_q(cnt)
    );

    bus_wake_ctrl #(
        .K_CYCLES(K_CYCLES), .SE0_CYCLES(SE0_CYCLES),
        .TAIL_CYCLES(TAIL_CYCLES), .CW(CW)
    ) ctrl_i (
        .clk(clk), .rst(rst), .start(start), .ctx_in(ctx_in), .cnt(cnt),
        .cnt_clr(cnt_clr), .phase_q(phase_q), .ctx_q(ctx_q), .hs_pulse(hs_mode_req)
    );

    assign line_code = phase_to_line(phase_q);
endmodule

// File: rtl/bus_wake_checker.sv
module bus_wake_checker
    import bus_wake_pkg::*;
#(
    parameter int unsigned SE0_CYCLES = 80
) (
    input logic       clk,
    input logic       rst,
    input logic       wake_evt,
    input logic       role_host,
    input logic       auto_q,
    input logic       ctx_host,
    input logic       ctx_hs,
    input logic [1:0] line_code,
    input logic       hs_mode_req
);
    int unsigned se0_len;

    always_ff @(posedge clk) begin
        if (rst)                    se0_len <= 0;
        else if (line_code == LN_SE0) se0_len <= se0_len + 1;
        else                        se0_len <= 0;
    end

    p_reset_state_r7: assert property (@(posedge clk)
        rst |=> (line_code == LN_RELEASE && !hs_mode_req && !auto_q));

    p_auto_clear_r1: assert property (@(posedge clk)
        rst |=> !auto_q);

    p_start_k_r2: assert property (@(posedge clk) disable iff (rst)
        (line_code == LN_RELEASE && wake_evt && (auto_q || !role_host)) |=> line_code == LN_K);

    p_se0_length_r3: assert property (@(posedge clk) disable iff (rst)
        (line_code != LN_SE0 && se0_len != 0 && ctx_host) |-> se0_len == SE0_CYCLES);

    p_hs_in_window_r4: assert property (@(posedge clk) disable iff (rst)
        hs_mode_req |-> (line_code == LN_SE0 && ctx_hs && ctx_host));

    p_dev_no_se0_r5: assert property (@(posedge clk) disable iff (rst)
        (line_code == LN_K && !ctx_host) |=> line_code != LN_SE0);

    p_ctx_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (line_code != LN_RELEASE && $past(line_code != LN_RELEASE)) |-> $stable({ctx_host, ctx_hs}));
endmodule

bind bus_wake_sequencer bus_wake_checker #(.SE0_CYCLES(SE0_CYCLES)) chk_i (
    .clk(clk), .rst(rst), .wake_evt(wake_evt), .role_host(role_host),
    .auto_q(auto_q), .ctx_host(ctx_q.host), .ctx_hs(ctx_q.was_hs),
    .line_code(line_code), .hs_mode_req(hs_mode_req)
);

// File: tb/bus_wake_sequencer_tb_top.sv
`timescale 1ns/1ps
module bus_wake_sequencer_tb_top;
    localparam int KC = 12;
    localparam int SC = 8;
    localparam int TC = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic auto_we = 1'b0, auto_wdata = 1'b0, wake_evt = 1'b0, role_host = 1'b0;
    logic [1:0] link_speed = 2'b00;
    logic [1:0] line_code;
    logic hs_mode_req;
    int vectors = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bus_wake_sequencer #(.K_CYCLES(KC), .SE0_CYCLES(SC), .TAIL_CYCLES(TC)) dut_i (
        .clk(clk), .rst(rst), .auto_we(auto_we), .auto_wdata(auto_wdata),
        .wake_evt(wake_evt), .role_host(role_host), .link_speed(link_speed),
        .line_code(line_code), .hs_mode_req(hs_mode_req)
    );

    function automatic logic [1:0] exp_line(bit host, logic [1:0] spd, int i);
        if (i <= KC) return 2'b01;
        if (host) return (i <= KC + SC) ? 2'b10 : 2'b00;
        if (spd != 2'b00 && i <= KC + TC) return 2'b11;
        return 2'b00;
    endfunction

    function automatic logic exp_hs(bit host, logic [1:0] spd, int i);
        return host && spd == 2'b00 && i == KC + 1 + SC / 2;
    endfunction

    function automatic string tag_for(bit host, int i, bit noisy);
        if (noisy) return "R6";
        if (i <= KC) return "R2";
        return host ? "R3" : "R5";
    endfunction

    task automatic check(string tag, string what, logic [1:0] act, logic [1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic write_auto(logic v);
        @(negedge clk); auto_we = 1'b1; auto_wdata = v;
        @(negedge clk); auto_we = 1'b0;
    endtask

    // one wake scenario; auto_on is what the bench believes the enable bit holds
    task automatic scenario(bit host, logic [1:0] spd, bit auto_on, bit noisy);
        bit go;
        int len;
        go = host ? auto_on : 1'b1;
        len = KC + (host ? SC : ((spd != 2'b00) ? TC : 0));
        @(negedge clk);
        role_host = host; link_speed = spd; wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
        for (int i = 1; i <= len + 3; i++) begin
            if (go) begin
                check(tag_for(host, i, noisy), "line", line_code, exp_line(host, spd, i));
                check(noisy ? "R6" : "R4", "hs_req", {1'b0, hs_mode_req},
                      {1'b0, exp_hs(host, spd, i)});
            end else begin
                check("R2", "line_no_auto", line_code, 2'b00);
            end
            if (noisy && i <= len) begin
                wake_evt   = 1'($urandom_range(0, 1));
                role_host  = 1'($urandom_range(0, 1));
                link_speed = 2'($urandom_range(0, 3));
            end else begin
                wake_evt = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R7", "line_in_reset", line_code, 2'b00);
        check("R7", "hs_in_reset", {1'b0, hs_mode_req}, 2'b00);
        rst = 1'b0;
        @(negedge clk);
        check("R7", "line_after_reset", line_code, 2'b00);
        // R1: enable is 0 after reset, so a host wake does nothing
        scenario(1'b1, 2'b00, 1'b0, 1'b0);
        // device starts without the enable bit
        for (int s = 0; s < 4; s++) scenario(1'b0, 2'(s), 1'b0, 1'b0);
        write_auto(1'b1);
        for (int s = 0; s < 4; s++) scenario(1'b1, 2'(s), 1'b1, 1'b0);
        // R6 noise during active sequences
        scenario(1'b1, 2'b00, 1'b1, 1'b1);
        scenario(1'b0, 2'b01, 1'b1, 1'b1);
        scenario(1'b0, 2'b00, 1'b1, 1'b1);
        // R1: clearing the bit again disables host wake
        write_auto(1'b0);
        scenario(1'b1, 2'b00, 1'b0, 1'b0);
        write_auto(1'b1);
        for (int n = 0; n < 40; n++) begin
            scenario(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 1'b1,
                     1'($urandom_range(0, 1)));
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule